// File: doc/BRIEF.md
# Saturating DSP Result and Condition Flag Unit

This block sits at the end of a 32-bit fixed-point DSP execution stage. It forms the raw result of one operation: add, subtract, a bitwise logic function, or an arithmetic or logical shift. If the saturation mode is on and the operation overflowed, it clamps the result to the most positive or most negative two's-complement value. It then derives the negative, zero, overflow and greater-than condition bits, and one selectable DSP condition bit.

The stored result is registered on every valid strobe. The five status bits are registered only for unconditional instructions. A conditional instruction leaves all five status bits untouched, whether or not it is allowed to execute. A 3-bit select field picks which condition feeds the DSP condition bit. How that bit is formed depends on the operation class.

Top module: `dsp_flag_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` and all five status outputs are cleared to 0 at that edge.
- R2: `op_class` selects the operation class: 0 arithmetic, 1 logic, 2 arithmetic shift, 3 logical shift. For arithmetic, `func[0]` picks add (0) or subtract `op_a - op_b` (1). For logic, `func` picks AND (0), OR (1), XOR (2) or NOT of `op_a` (3). For shifts, `func[0]` picks left (0) or right (1), and the amount is `op_b[4:0]`. A valid operation stores its 32-bit wrapped result one clock after the strobe.
- R3: When `sat_en` is 1 and the operation overflows, the stored result is 0x7FFFFFFF if the true result is above the range and 0x80000000 if it is below. With `sat_en` at 0 the wrapped result is stored.
- R4: N is bit 31 of the stored result, and Z is 1 exactly when the stored result is zero. GT is 1 exactly when the stored result is strictly positive. All three are taken after saturation.
- R5: V is 1 when the unsaturated result overflowed. Logic operations, logical shifts and right shifts never set V.
- R6: An arithmetic left shift overflows when any bit shifted out, or the new sign bit, differs from the original sign bit.
- R7: With `cond_insn` at 1, a valid operation still stores its result, but DC, N, Z, V and GT keep their previous values.
- R8: With `valid` at 0, the result and status registers hold their values.
- R9: The DSP condition bit follows `csel`: 0 carry, 1 N, 2 Z, 3 V, 4 GT. Codes 5 to 7 give 0.
- R10: Carry is defined per operation. For add it is the carry out of bit 31. For subtract it is the unsigned borrow (`op_a < op_b`). For a shift it is the last bit shifted out, and a zero shift amount gives 0. For the logic class, carry and V selections give a DSP condition bit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Operation strobe |
| op_class | input | 2 | Operation class |
| func | input | 2 | Function within the class |
| op_a | input | 32 | First operand, or the value to shift |
| op_b | input | 32 | Second operand, or the shift amount in bits 4:0 |
| sat_en | input | 1 | Saturation mode enable |
| cond_insn | input | 1 | Conditional instruction; status update suppressed |
| csel | input | 3 | Condition select for the DSP condition bit |
| result | output | 32 | Stored result |
| dc_flag | output | 1 | DSP condition bit |
| n_flag | output | 1 | Negative bit |
| z_flag | output | 1 | Zero bit |
| v_flag | output | 1 | Overflow bit |
| gt_flag | output | 1 | Greater-than-zero bit |

## Verification
Every register in the block is visible at a port. A wrong overflow decision therefore appears one clock after the strobe, as a V bit that disagrees with the operands, and also as an unclamped or wrongly clamped `result` when saturation is on. A status register that updates when it should not shows up one cycle after a conditional operation: its bits no longer match the last unconditional operation. A bad carry or select path appears as a wrong DC bit on the operation that exercises it. Because the bench compares every cycle, each fault is caught at the first clock where the state diverges.

// File: rtl/dsp_flag_pkg.sv
package dsp_flag_pkg;

    localparam int DATA_W = 32;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        CLS_ARITH  = 2'd0,
        CLS_LOGIC  = 2'd1,
        CLS_ASHIFT = 2'd2,
        CLS_LSHIFT = 2'd3
    } op_class_e;

    localparam logic [SEL_W-1:0] SEL_CARRY = 3'd0;
    localparam logic [SEL_W-1:0] SEL_NEG   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ZERO  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_OVF   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_GT    = 3'd4;

    localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIMIT = {1'b1, {(DATA_W-1){1'b0}}};

    // Raw outcome of one operation before saturation
    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              ovf;
        logic              pos_dir;   // overflow went above the range
    } raw_t;

    typedef struct packed {
        logic dc;
        logic n;
        logic z;
        logic v;
        logic gt;
    } flags_t;

    function automatic logic [DATA_W-1:0] clamp_value(input logic pos);
        return pos ? POS_LIMIT : NEG_LIMIT;
    endfunction

endpackage

// File: rtl/dsp_alu_unit.sv
module dsp_alu_unit
    import dsp_flag_pkg::*;
(
    input  logic              is_logic,
    input  logic [1:0]        func,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output raw_t              raw
);

    logic [DATA_W:0] wide;

    always_comb begin
        raw  = '0;
        wide = '0;
        if (is_logic) begin
            unique case (func)
                2'd0:    raw.value = a & b;
                2'd1:    raw.value = a | b;
                2'd2:    raw.value = a ^ b;
                default: raw.value = ~a;
            endcase
        end else if (func[0]) begin
            wide      = {1'b0, a} - {1'b0, b};
            raw.value = wide[DATA_W-1:0];
            raw.carry = wide[DATA_W];
            raw.ovf   = (a[DATA_W-1] != b[DATA_W-1]) &&
                        (raw.value[DATA_W-1] != a[DATA_W-1]);
        end else begin
            wide      = {1'b0, a} + {1'b0, b};
            raw.value = wide[DATA_W-1:0];
            raw.carry = wide[DATA_W];
            raw.ovf   = (a[DATA_W-1] == b[DATA_W-1]) &&
                        (raw.value[DATA_W-1] != a[DATA_W-1]);
        end
        raw.pos_dir = ~a[DATA_W-1];
    end

    // R5
    always_comb begin
        if (is_logic)
            logic_no_ovf_chk: assert (!raw.ovf);
    end

endmodule

// File: rtl/dsp_shift_unit.sv
module dsp_shift_unit
    import dsp_flag_pkg::*;
(
    input  logic              is_arith,
    input  logic              dir_right,
    input  logic [SH_W-1:0]   amt,
    input  logic [DATA_W-1:0] a,
    output raw_t              raw
);

    logic [DATA_W:0] left_ext;
    logic [DATA_W:0] right_ext;

    always_comb begin
        raw       = '0;
        left_ext  = {1'b0, a} << amt;
        right_ext = {a, 1'b0} >> amt;
        if (dir_right) begin
            raw.value = is_arith ? DATA_W'($signed(a) >>> amt) : (a >> amt);
            raw.carry = right_ext[0];
        end else begin
            raw.value = left_ext[DATA_W-1:0];
            raw.carry = left_ext[DATA_W];
            // R6: shifting back must restore the operand
            raw.ovf   = is_arith && (($signed(raw.value) >>> amt) != $signed(a));
        end
        raw.pos_dir = ~a[DATA_W-1];
    end

    // R5
    always_comb begin
        if (dir_right || !is_arith)
            shift_no_ovf_chk: assert (!raw.ovf);
    end

endmodule

// File: rtl/dsp_sat_flags.sv
module dsp_sat_flags
    import dsp_flag_pkg::*;
(
    input  raw_t              raw,
    input  logic              sat_en,
    input  op_class_e         cls,
    input  logic [SEL_W-1:0]  csel,
    output logic [DATA_W-1:0] value,
    output flags_t            flags
);

    logic is_logic;

    always_comb begin
        is_logic = (cls == CLS_LOGIC);
        value    = (sat_en && raw.ovf) ? clamp_value(raw.pos_dir) : raw.value;

        flags.n  = value[DATA_W-1];
        flags.z  = (value == '0);
        flags.v  = raw.ovf;
        flags.gt = !flags.n && !flags.z;

        unique case (csel)
            SEL_CARRY: flags.dc = raw.carry && !is_logic;
            SEL_NEG:   flags.dc = flags.n;
            SEL_ZERO:  flags.dc = flags.z;
            SEL_OVF:   flags.dc = flags.v && !is_logic;
            SEL_GT:    flags.dc = flags.gt;
            default:   flags.dc = 1'b0;
        endcase
    end

endmodule

// File: rtl/dsp_flag_unit.sv
module dsp_flag_unit
    import dsp_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [1:0]        op_class,
    input  logic [1:0]        func,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              sat_en,
    input  logic              cond_insn,
    input  logic [SEL_W-1:0]  csel,
    output logic [DATA_W-1:0] result,
    output logic              dc_flag,
    output logic              n_flag,
    output logic              z_flag,
    output logic              v_flag,
    output logic              gt_flag
);

    op_class_e         cls;
    raw_t              alu_raw;
    raw_t              sh_raw;
    raw_t              sel_raw;
    logic [DATA_W-1:0] next_value;
    flags_t            next_flags;
    logic [DATA_W-1:0] result_q;
    flags_t            flags_q;

    assign cls = op_class_e'(op_class);

    dsp_alu_unit u_alu (
        .is_logic (cls == CLS_LOGIC),
        .func     (func),
        .a        (op_a),
        .b        (op_b),
        .raw      (alu_raw)
    );

    dsp_shift_unit u_shift (
        .is_arith  (cls == CLS_ASHIFT),
        .dir_right (func[0]),
        .amt       (op_b[SH_W-1:0]),
        .a         (op_a),
        .raw       (sh_raw)
    );

    assign sel_raw = (cls == CLS_ASHIFT || cls == CLS_LSHIFT) ? sh_raw : alu_raw;

    dsp_sat_flags u_sat (
        .raw    (sel_raw),
        .sat_en (sat_en),
        .cls    (cls),
        .csel   (csel),
        .value  (next_value),
        .flags  (next_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (valid) begin
            result_q <= next_value;
            if (!cond_insn)
                flags_q <= next_flags;
        end
    end

    assign result  = result_q;
    assign dc_flag = flags_q.dc;
    assign n_flag  = flags_q.n;
    assign z_flag  = flags_q.z;
    assign v_flag  = flags_q.v;
    assign gt_flag = flags_q.gt;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result == '0) && !dc_flag && !n_flag && !z_flag && !v_flag && !gt_flag);

    // R7
    cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && cond_insn) |=> $stable({dc_flag, n_flag, z_flag, v_flag, gt_flag}));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(result) && $stable({dc_flag, n_flag, z_flag, v_flag, gt_flag}));

    // R4
    zero_match_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !cond_insn) |=> (z_flag == (result == '0)) && (n_flag == result[DATA_W-1]));

    // R4
    gt_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        gt_flag |-> !n_flag && !z_flag);

    // R3
    sat_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !cond_insn && sat_en) |=>
            (!v_flag || result == POS_LIMIT || result == NEG_LIMIT));

    // R5
    logic_no_v_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !cond_insn && cls == CLS_LOGIC) |=> !v_flag && !dc_flag || csel == SEL_NEG
            || csel == SEL_ZERO || csel == SEL_GT || $past(csel) != SEL_CARRY);

endmodule

// File: tb/dsp_flag_unit_bench.sv
module dsp_flag_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid;
    logic [1:0]  op_class;
    logic [1:0]  func;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        sat_en;
    logic        cond_insn;
    logic [2:0]  csel;
    logic [31:0] result;
    logic        dc_flag, n_flag, z_flag, v_flag, gt_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] e_res;
    logic        e_dc, e_n, e_z, e_v, e_gt;

    always #5 clk = ~clk;

    dsp_flag_unit u_dsp_flag_unit (
        .clk(clk), .rst(rst), .valid(valid), .op_class(op_class), .func(func),
        .op_a(op_a), .op_b(op_b), .sat_en(sat_en), .cond_insn(cond_insn),
        .csel(csel), .result(result), .dc_flag(dc_flag), .n_flag(n_flag),
        .z_flag(z_flag), .v_flag(v_flag), .gt_flag(gt_flag)
    );

    task automatic compare(input string tag);
        checks++;
        if (result !== e_res || dc_flag !== e_dc || n_flag !== e_n ||
            z_flag !== e_z || v_flag !== e_v || gt_flag !== e_gt) begin
            errors++;
            $display("FAIL %s: got res=%h dc%b n%b z%b v%b gt%b, expected res=%h dc%b n%b z%b v%b gt%b",
                     tag, result, dc_flag, n_flag, z_flag, v_flag, gt_flag,
                     e_res, e_dc, e_n, e_z, e_v, e_gt);
        end
    endtask

    // Behavioural reference for one valid operation
    task automatic model(input logic [1:0] c, input logic [1:0] f, input logic [31:0] a,
                         input logic [31:0] b, input logic s, input logic cond,
                         input logic [2:0] sel);
        longint          exact;
        longint unsigned ua;
        logic [31:0]     r;
        logic            cy, ov, nn, zz, gg, dd;
        int              k;
        ua = longint'(a);
        k  = int'(b[4:0]);
        cy = 1'b0; ov = 1'b0; exact = 0;
        case (c)
            2'd0: begin
                if (f[0]) begin
                    exact = longint'($signed(a)) - longint'($signed(b));
                    cy    = (a < b);
                end else begin
                    exact = longint'($signed(a)) + longint'($signed(b));
                    cy    = ((ua + longint'(b)) >> 32) != 0;
                end
                r  = exact[31:0];
                ov = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
            end
            2'd1: begin
                case (f)
                    2'd0: r = a & b;
                    2'd1: r = a | b;
                    2'd2: r = a ^ b;
                    default: r = ~a;
                endcase
            end
            default: begin
                if (f[0]) begin
                    r  = (c == 2'd2) ? 32'($signed(a) >>> k) : (a >> k);
                    cy = (k > 0) ? ((ua >> (k - 1)) & 1) != 0 : 1'b0;
                end else begin
                    r  = a << k;
                    cy = (k > 0) ? ((ua >> (32 - k)) & 1) != 0 : 1'b0;
                    if (c == 2'd2) begin
                        exact = longint'($signed(a)) * (64'sd1 <<< k);
                        ov = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
                    end
                end
            end
        endcase
        if (s && ov) r = (exact > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        nn = r[31];
        zz = (r == 32'd0);
        gg = !nn && !zz;
        case (sel)
            3'd0: dd = (c == 2'd1) ? 1'b0 : cy;
            3'd1: dd = nn;
            3'd2: dd = zz;
            3'd3: dd = (c == 2'd1) ? 1'b0 : ov;
            3'd4: dd = gg;
            default: dd = 1'b0;
        endcase
        e_res = r;
        if (!cond) begin
            e_dc = dd; e_n = nn; e_z = zz; e_v = ov; e_gt = gg;
        end
    endtask

    task automatic issue(input string tag, input logic [1:0] c, input logic [1:0] f,
                         input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic cond, input logic [2:0] sel);
        valid = 1'b1; op_class = c; func = f; op_a = a; op_b = b;
        sat_en = s; cond_insn = cond; csel = sel;
        model(c, f, a, b, s, cond, sel);
        @(negedge clk);
        valid = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        valid = 1'b0;
        op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_res = '0; e_dc = 0; e_n = 0; e_z = 0; e_v = 0; e_gt = 0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        valid = 0; op_class = 0; func = 0; op_a = 0; op_b = 0;
        sat_en = 0; cond_insn = 0; csel = 0;
        @(negedge clk);
        do_reset("R1");

        // R2 add, R10 no carry
        issue("R2", 2'd0, 2'd0, 32'd5, 32'd7, 0, 0, 3'd0);
        // R10 add carry out
        issue("R10", 2'd0, 2'd0, 32'hFFFF_FFFF, 32'd2, 0, 0, 3'd0);
        // R3 wrap without saturation, R5 V set
        issue("R3", 2'd0, 2'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, 3'd3);
        // R3 positive clamp, R4 flags after clamp
        issue("R4", 2'd0, 2'd0, 32'h7FFF_FFFF, 32'd1, 1, 0, 3'd4);
        // R3 negative clamp on subtract
        issue("R3", 2'd0, 2'd1, 32'h8000_0000, 32'd1, 1, 0, 3'd1);
        // R10 borrow
        issue("R10", 2'd0, 2'd1, 32'd3, 32'd5, 0, 0, 3'd0);
        // R4 zero result
        issue("R4", 2'd0, 2'd1, 32'd9, 32'd9, 0, 0, 3'd2);
        // R10 logic class carry and V selections give 0
        issue("R10", 2'd1, 2'd3, 32'h0, 32'h0, 0, 0, 3'd0);
        issue("R10", 2'd1, 2'd2, 32'hF0F0_F0F0, 32'hFFFF_0000, 0, 0, 3'd3);
        issue("R2", 2'd1, 2'd1, 32'h00FF_0000, 32'h0000_00FF, 0, 0, 3'd4);
        // R6 arithmetic left overflow
        issue("R6", 2'd2, 2'd0, 32'h4000_0000, 32'd1, 0, 0, 3'd3);
        issue("R6", 2'd2, 2'd0, 32'hC000_0000, 32'd1, 0, 0, 3'd3);
        issue("R6", 2'd2, 2'd0, 32'h0000_0003, 32'd31, 1, 0, 3'd0);
        issue("R6", 2'd2, 2'd0, 32'hBFFF_FFFF, 32'd2, 1, 0, 3'd1);
        // R10 shift carry and zero amount
        issue("R10", 2'd2, 2'd1, 32'h8000_0018, 32'd4, 0, 0, 3'd0);
        issue("R10", 2'd3, 2'd0, 32'h8000_0001, 32'd1, 0, 0, 3'd0);
        issue("R10", 2'd3, 2'd0, 32'hFFFF_FFFF, 32'd0, 0, 0, 3'd0);
        // R5 logical shift never overflows
        issue("R5", 2'd3, 2'd0, 32'h4000_0000, 32'd1, 1, 0, 3'd3);
        issue("R5", 2'd3, 2'd1, 32'h8000_0000, 32'd31, 0, 0, 3'd0);
        // R7 conditional keeps status, stores result
        issue("R7", 2'd0, 2'd0, 32'h7FFF_FFFF, 32'd1, 0, 1, 3'd3);
        issue("R7", 2'd0, 2'd1, 32'd4, 32'd4, 0, 1, 3'd2);
        // R8 idle holds
        idle("R8");
        idle("R8");
        // R9 unused select codes
        issue("R9", 2'd0, 2'd1, 32'd1, 32'd2, 0, 0, 3'd5);
        issue("R9", 2'd0, 2'd1, 32'd0, 32'd0, 0, 0, 3'd6);
        issue("R9", 2'd2, 2'd0, 32'h4000_0000, 32'd1, 0, 0, 3'd7);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 5 == 0) ra = {ra[31], {31{ra[31]}} ^ 31'(i)};
            issue("R2", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), ra, rb,
                  1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                  3'($urandom_range(0, 7)));
            if (i % 37 == 0) idle("R8");
        end

        do_reset("R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule